// File: doc/BRIEF.md
# Pushbutton Debouncer with Delayed Re-check

This block turns a noisy, active-low pushbutton into a clean sticky "pressed" indication. A pressed button reads as logic 0. The raw pin first passes through a two-stage synchronizer. A falling edge on the synchronized level then starts a one-shot delay window. Each count of the window lasts a fixed number of clock cycles, so the window is `DELAY_TICKS * TICK_DIV` cycles long. With the default values it is 20000 ticks of a quarter-rate tick, which is 20 ms at a 4 MHz clock.

When the window ends, the synchronized level is sampled exactly once. If the button still reads low at that moment, the sticky flag is set. Edges that arrive while the window is running are ignored. Once the flag is set it stays set until the consumer pulses the clear input, normally after it has seen the button released.

Top module: `btn_recheck_debouncer`

## Requirements
- R1: After reset `pressed` is 0 and no delay window is running.
- R2: A falling edge starts a window of `DELAY_TICKS*TICK_DIV` cycles. When the button is held low, `pressed` rises exactly `DELAY_TICKS*TICK_DIV + 3` clock edges after the first edge that samples `btn_n` low, and is still 0 one edge earlier. The 3 extra edges are two synchronizer stages plus the edge-detect register.
- R3: The single check at the end of the window sets `pressed` only if the synchronized level is 0 at that moment. A button released before the check leaves `pressed` at 0.
- R4: Falling edges that occur while a window is running do not restart or extend it. The check still happens at the time set by the first edge.
- R5: Each falling edge gives at most one check. After the check the timer idles. A button that is held low without a new falling edge never sets `pressed` again.
- R6: Once set, `pressed` stays 1 while `clr` is 0, whatever the button does.
- R7: `pressed` reads 0 on the cycle after `clr` is sampled high.
- R8: When `clr` is high in the same cycle as a successful check, the clear wins and `pressed` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Raw pushbutton level, active low, asynchronous to `clk` |
| clr | input | 1 | Clears the sticky flag; takes priority over a set |
| pressed | output | 1 | Sticky flag: a press survived the delayed re-check |

## Verification
A wrong internal state shows up at the ports in specific ways:
- A timer that restarts on edges inside the window, or that counts one tick too many or too few, moves the rise of `pressed` away from its exact edge.
- A check that samples the level at the wrong point flips the outcome for releases close to the end of the window. The bench therefore sweeps the release time across every cycle of a small window.
- A timer that does not disarm after its check sets the flag again while the button is held. This is visible within one further window after a clear.
- A wrong clear priority shows on the very next edge.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_RUN  = 1'b1
  } win_state_t;
endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dbn_delay.sv
module dbn_delay
  import dbn_pkg::*;
#(
  parameter int DELAY_TICKS = 20000,
  parameter int TICK_DIV    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic expire
);
  localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

  win_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign busy = (state_q == WIN_RUN);

  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam int PRE_W = $clog2(TICK_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pre_q <= '0;
        else if (!busy)         pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
      end
      assign tick = busy && (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign tick = busy;
    end
  endgenerate

  assign expire = tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        WIN_IDLE: if (start) begin
          state_q <= WIN_RUN;
          cnt_q   <= '0;
        end
        WIN_RUN: begin
          if (expire)    state_q <= WIN_IDLE;
          else if (tick) cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= WIN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/btn_recheck_debouncer.sv
module btn_recheck_debouncer #(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_TICKS = 20000,
  parameter int TICK_DIV    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  input  logic clr,
  output logic pressed
);
  logic lvl;
  logic lvl_prev_q;
  logic fall;
  logic busy;
  logic expire;
  logic pressed_q;

  dbn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (btn_n),
    .dout (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev_q <= 1'b1;
    else        lvl_prev_q <= lvl;
  end

  assign fall = lvl_prev_q && !lvl;

  dbn_delay #(.DELAY_TICKS(DELAY_TICKS), .TICK_DIV(TICK_DIV)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fall),
    .busy  (busy),
    .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pressed_q <= 1'b0;
    else if (clr)               pressed_q <= 1'b0;
    else if (expire && !lvl)    pressed_q <= 1'b1;
  end

  assign pressed = pressed_q;
endmodule

// File: rtl/dbn_checker.sv
module dbn_checker #(
  parameter int WIN = 80000
) (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic pressed,
  input logic lvl,
  input logic fall,
  input logic busy,
  input logic expire
);
  int unsigned wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wcnt <= 0;
    else if (busy) wcnt <= wcnt + 1;
    else           wcnt <= 0;
  end

  p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fall));

  p_window_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (wcnt == WIN - 1));

  p_set_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pressed) |-> $past(expire && !lvl && !clr));

  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire) |=> busy);

  p_one_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !busy);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pressed && !clr) |=> pressed);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pressed);
endmodule

bind btn_recheck_debouncer dbn_checker #(.WIN(DELAY_TICKS * TICK_DIV)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clr    (clr),
  .pressed(pressed),
  .lvl    (lvl),
  .fall   (fall),
  .busy   (busy),
  .expire (expire)
);

// File: tb/btn_recheck_debouncer_tb.sv
module btn_recheck_debouncer_tb;
  localparam int DT  = 5;
  localparam int DV  = 2;
  localparam int WIN = DT * DV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic clr = 1'b0;
  logic pressed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  btn_recheck_debouncer #(.SYNC_STAGES(2), .DELAY_TICKS(DT), .TICK_DIV(DV)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .btn_n  (btn_n),
    .clr    (clr),
    .pressed(pressed)
  );

  task automatic chk(input logic exp, input string req);
    checks++;
    if (pressed !== exp) begin
      errors++;
      $display("FAIL %s: pressed=%b expected=%b at %0t", req, pressed, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    edges(1);
    clr = 1'b0;
  endtask

  initial begin
    edges(2);
    chk(1'b0, "R1");
    rst_n = 1'b1;
    edges(2);
    chk(1'b0, "R1");

    // R2 R3 R6 R7: sweep the release edge d over the whole window
    for (int d = 1; d <= WIN + 4; d++) begin
      logic exp_set;
      exp_set = (d >= WIN + 1);
      btn_n = 1'b0;
      for (int e = 1; e <= WIN + 4; e++) begin
        edges(1);
        if (e == d) btn_n = 1'b1;
        if (e == WIN + 2) chk(1'b0, "R2");
        if (e == WIN + 3) chk(exp_set, "R3");
      end
      btn_n = 1'b1;
      edges(10);
      chk(exp_set, "R6");
      do_clear();
      chk(1'b0, "R7");
      edges(4);
    end

    // R4: glitch inside the window must not restart it
    btn_n = 1'b0;
    for (int e = 1; e <= WIN + 3; e++) begin
      edges(1);
      if (e == 2) btn_n = 1'b1;
      if (e == 4) btn_n = 1'b0;
      if (e == WIN + 2) chk(1'b0, "R4");
      if (e == WIN + 3) chk(1'b1, "R4");
    end
    btn_n = 1'b1;
    edges(4);
    do_clear();
    edges(4);

    // R8: clear coincides with the successful check
    btn_n = 1'b0;
    for (int e = 1; e <= WIN + 3; e++) begin
      edges(1);
      if (e == WIN + 2) clr = 1'b1;
      if (e == WIN + 3) begin
        chk(1'b0, "R8");
        clr = 1'b0;
      end
    end

    // R5: held low with no new edge, no second check
    edges(3 * WIN);
    chk(1'b0, "R5");
    btn_n = 1'b1;
    edges(6);
    chk(1'b0, "R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule